// File: doc/BRIEF.md
# First-Order Delta-Sigma Modulator with Ones Counter

This block is a cycle-accurate digital model of a single-loop, first-order delta-sigma converter. An unsigned N-bit level is presented on the input and held steady, and a start pulse opens a conversion window. In every clock of the window the loop forms the difference between the level and the value of the bit it produced last, adds that difference into a signed integrator, and decides the next bit by comparing the integrator with a fixed threshold of zero. A positive integrator means the bits so far stand for too little, so the next bit is 1; otherwise it is 0.

A counter tallies the 1 bits produced during a window of exactly 2^N-1 bit cycles. When the window closes, the tally is latched onto the result output and a one-clock done strobe is raised. The bitstream itself is also brought out, with its own valid strobe, so that a consumer can filter it differently.

A bit of 0 stands for full-scale low (0) and a bit of 1 for full-scale high (2^N-1). With this scaling the tally tracks the input level to within one code.

Top module: `dsm_converter`

## Requirements
- R1: During and right after synchronous reset, done_o, stream_o, stream_vld_o and result_o are all 0.
- R2: Each accepted start produces exactly 2^N-1 cycles with stream_vld_o high, one bit per cycle. done_o rises in the same cycle as the last valid bit, 256 clocks after the cycle in which start_i is driven (N=8).
- R3: The signed integrator, N+2 bits wide, stays in the range (-(2^N-1), 2^N-1] for every legal input and never wraps.
- R4: Each bit is 1 exactly when the integrator is above zero after adding (level minus the previous bit's value). A 1 bit therefore makes the next update add level-(2^N-1), and a 0 bit makes it add level. For level 128 with N=8, the first three bits are 1, 1, 0.
- R5: result_o equals the number of 1 bits seen on stream_o while stream_vld_o was high in that window.
- R6: For every level x in 1..2^N-2, result_o is x or x-1.
- R7: Level 0 gives an all-zero stream and result 0. Level 2^N-1 gives an all-one stream and result 2^N-1.
- R8: done_o is high for exactly one clock. result_o keeps its value from one done pulse to the next, including during the following conversion.
- R9: start_i while a conversion is running is ignored. The window length and the result are unchanged.
- R10: An accepted start clears the integrator and the previous-bit feedback. Two conversions of the same level give identical results and identical opening bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a conversion window when idle |
| level_i | input | N | Unsigned input level, held steady during a window |
| stream_o | output | 1 | Modulator bitstream |
| stream_vld_o | output | 1 | stream_o carries a bit of the current window |
| result_o | output | N | Count of 1 bits of the last finished window |
| done_o | output | 1 | One-clock strobe: result_o has just been updated |

## Verification
Level 0 and full scale expose the extremes, where any sign or threshold mistake turns the stream solid in the wrong direction. A sweep of mid-scale levels that includes 1, 127, 128 and 2^N-2 separates a correct one-LSB error bound from off-by-one windows or a wrong feedback value. The opening bits at level 128 pin down the comparison against zero and the feedback polarity. A repeated conversion, and a restart attempted mid-window, tell a properly cleared and protected loop from one that carries state over or restarts.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Full-scale code for an n-bit level: the value a 1 bit stands for.
    function automatic int unsigned full_scale(input int unsigned n);
        return (32'd1 << n) - 32'd1;
    endfunction

    // Integrator width: two bits of headroom above the level width.
    function automatic int unsigned integ_width(input int unsigned n);
        return n + 2;
    endfunction

endpackage

// File: rtl/dsm_sequencer.sv
module dsm_sequencer #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic clear_o,
    output logic step_o,
    output logic last_o,
    output logic vld_o,
    output logic done_o
);
    import dsm_pkg::*;

    localparam int unsigned WIN = full_scale(N);
    localparam logic [N-1:0] LAST_IDX = N'(WIN - 1);

    seq_state_t     state_q;
    logic [N-1:0]   cyc_q;
    logic           vld_q;
    logic           done_q;

    assign clear_o = start_i && (state_q == SEQ_IDLE);
    assign step_o  = (state_q == SEQ_RUN);
    assign last_o  = step_o && (cyc_q == LAST_IDX);
    assign vld_o   = vld_q;
    assign done_o  = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cyc_q   <= '0;
            vld_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            vld_q  <= step_o;
            done_q <= last_o;
            if (clear_o) begin
                state_q <= SEQ_RUN;
                cyc_q   <= '0;
            end else if (last_o) begin
                state_q <= SEQ_IDLE;
                cyc_q   <= '0;
            end else if (step_o) begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    // R8: done lasts one clock
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R2: done arrives as the run ends
    assert_window_end_R2: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state_q == SEQ_IDLE) && ($past(state_q) == SEQ_RUN));

    // R9: a start while running neither restarts nor stalls the window
    assert_restart_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (step_o && start_i && !last_o) |=> (state_q == SEQ_RUN) && (cyc_q == $past(cyc_q) + 1'b1));

endmodule

// File: rtl/dsm_loop.sv
module dsm_loop #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic [N-1:0] level_i,
    output logic         bit_nx_o,
    output logic         bit_o
);
    import dsm_pkg::*;

    localparam int AW = integ_width(N);
    localparam logic signed [AW-1:0] FS_S   = AW'(full_scale(N));
    localparam logic signed [AW-1:0] THRESH = '0;

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] acc_nx;
    logic signed [AW-1:0] lvl_s;
    logic signed [AW-1:0] fb_s;
    logic                 bit_q;

    always_comb begin
        lvl_s  = $signed({2'b00, level_i});
        fb_s   = bit_q ? FS_S : '0;
        acc_nx = acc_q + (lvl_s - fb_s);
    end

    assign bit_nx_o = (acc_nx > THRESH);
    assign bit_o    = bit_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            acc_q <= '0;
            bit_q <= 1'b0;
        end else if (step_i) begin
            acc_q <= acc_nx;
            bit_q <= bit_nx_o;
        end
    end

    // R3: integrator stays inside its proven range
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_q > -FS_S) && (acc_q <= FS_S));

    // R4: a 1 bit pulls the integrator down (or level), a 0 bit never lowers it
    assert_feedback_one_R4: assert property (@(posedge clk) disable iff (rst)
        (step_i && bit_q) |=> (acc_q <= $past(acc_q)));
    assert_feedback_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (step_i && !bit_q) |=> (acc_q >= $past(acc_q)));

    // R10: a start leaves a cleared loop
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (acc_q == '0) && !bit_q);

endmodule

// File: rtl/dsm_tally.sv
module dsm_tally #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic         last_i,
    input  logic         bit_nx_i,
    output logic [N-1:0] result_o
);
    logic [N-1:0] ones_q;
    logic [N-1:0] ones_nx;
    logic [N-1:0] result_q;

    assign ones_nx  = ones_q + N'(bit_nx_i);
    assign result_o = result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q   <= '0;
            result_q <= '0;
        end else begin
            if (clear_i)
                ones_q <= '0;
            else if (step_i)
                ones_q <= ones_nx;
            if (last_i)
                result_q <= ones_nx;
        end
    end

    // R8: result only moves when a window closes
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !last_i |=> $stable(result_q));

    // R5: the tally never shrinks inside a window
    assert_tally_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
        (step_i && !clear_i) |=> (ones_q >= $past(ones_q)) || $past(last_i));

endmodule

// File: rtl/dsm_converter.sv
module dsm_converter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [N-1:0] level_i,
    output logic         stream_o,
    output logic         stream_vld_o,
    output logic [N-1:0] result_o,
    output logic         done_o
);
    logic clear_w;
    logic step_w;
    logic last_w;
    logic bit_nx_w;

    dsm_sequencer #(.N(N)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .clear_o (clear_w),
        .step_o  (step_w),
        .last_o  (last_w),
        .vld_o   (stream_vld_o),
        .done_o  (done_o)
    );

    dsm_loop #(.N(N)) u_loop (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (clear_w),
        .step_i   (step_w),
        .level_i  (level_i),
        .bit_nx_o (bit_nx_w),
        .bit_o    (stream_o)
    );

    dsm_tally #(.N(N)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (clear_w),
        .step_i   (step_w),
        .last_i   (last_w),
        .bit_nx_i (bit_nx_w),
        .result_o (result_o)
    );

    // R7: the stream is only valid while a window runs, never alongside a stale done
    assert_stream_framing_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> stream_vld_o);

endmodule

// File: tb/test_dsm_converter.sv
module test_dsm_converter;
    localparam int N   = 8;
    localparam int FS  = (1 << N) - 1;
    localparam int LAT = FS + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [N-1:0] level_i = '0;
    logic         stream_o;
    logic         stream_vld_o;
    logic [N-1:0] result_o;
    logic         done_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dsm_converter #(.N(N)) i_dsm_converter (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .level_i      (level_i),
        .stream_o     (stream_o),
        .stream_vld_o (stream_vld_o),
        .result_o     (result_o),
        .done_o       (done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion; restart_at > 0 drives a stray start at that latency.
    task automatic run(input int x, input int restart_at, output int res, output int ones,
                       output int nval, output int lat, output logic [2:0] first3,
                       output int held_ok);
        int prev_res;
        @(negedge clk);
        prev_res = result_o;
        level_i  = N'(x);
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1; ones = 0; nval = 0; first3 = '0; held_ok = 1;
        forever begin
            if (stream_vld_o) begin
                if (nval < 3) first3[2 - nval] = stream_o;
                nval++;
                if (stream_o) ones++;
            end
            if (done_o) break;
            if (result_o != N'(prev_res)) held_ok = 0;
            if (lat > 2000) begin
                fails++;
                $display("FAIL watchdog: actual=%0d expected=%0d", lat, LAT);
                break;
            end
            start_i = (lat == restart_at);
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        res = result_o;
        @(negedge clk);
        check("R8 done one clock", done_o, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 done", done_o, 0);
        check("R1 stream", stream_o, 0);
        check("R1 valid", stream_vld_o, 0);
        check("R1 result", result_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 result after release", result_o, 0);
    endtask

    task automatic t_zero;
        int res, ones, nval, lat, h; logic [2:0] f;
        run(0, 0, res, ones, nval, lat, f, h);
        check("R7 zero result", res, 0);
        check("R7 zero ones", ones, 0);
        check("R2 window length", nval, FS);
        check("R2 done latency", lat, LAT);
    endtask

    task automatic t_full;
        int res, ones, nval, lat, h; logic [2:0] f;
        run(FS, 0, res, ones, nval, lat, f, h);
        check("R7 full result", res, FS);
        check("R7 full ones", ones, FS);
        check("R8 previous result held", h, 1);
    endtask

    task automatic t_sweep;
        int lv[8] = '{1, 37, 100, 127, 128, 171, 200, FS - 1};
        foreach (lv[i]) begin
            int res, ones, nval, lat, h; logic [2:0] f;
            run(lv[i], 0, res, ones, nval, lat, f, h);
            check("R6 within one code", int'(res == lv[i] || res == lv[i] - 1), 1);
            check("R5 result equals ones", res, ones);
            check("R2 window length", nval, FS);
            check("R4 first bit", f[2], 1);
        end
    endtask

    task automatic t_pattern_and_repeat;
        int r1, r2, o, n, l, h; logic [2:0] f1, f2;
        run(128, 0, r1, o, n, l, f1, h);
        check("R4 opening bits 110", int'(f1), 3'b110);
        run(128, 0, r2, o, n, l, f2, h);
        check("R10 repeat result", r2, r1);
        check("R10 repeat opening bits", int'(f2), int'(f1));
        check("R8 result held during run", h, 1);
    endtask

    task automatic t_restart_ignored;
        int r0, r1, o, n, l, h; logic [2:0] f;
        run(77, 0, r0, o, n, l, f, h);
        run(77, 40, r1, o, n, l, f, h);
        check("R9 window unchanged", n, FS);
        check("R9 latency unchanged", l, LAT);
        check("R9 result unchanged", r1, r0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_zero();
        t_full();
        t_sweep();
        t_pattern_and_repeat();
        t_restart_ignored();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule